// File: doc/BRIEF.md
# Routable Multi-Output Interrupt Controller

This block collects 32 level-sensitive interrupt requests and steers each one to one of 15 level outputs toward a processor. Software owns a per-input enable mask and a 4-bit route code for every input. A route code of zero leaves the input unconnected. Codes 1 through 15 pick output lines 0 through 14. A read-only status word shows the input levels after they have been synchronized to the block clock.

For a dual-processor system the register set is replicated into banks. Each bank has its own mask and route codes and drives its own group of 15 outputs. All banks see the same synchronized inputs. An input therefore reaches a given processor only when that processor's bank both enables it and gives it a nonzero route. Access is through a simple 32-bit register bus with a single-cycle write strobe and a read strobe whose data appears one cycle later.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every mask bit and every route code in every bank is 0, all outputs are low, and every mapped register reads 0.
- R2: The word at bank offset 0x00 is the mask. It can be written and read back, and bit n enables input n.
- R3: The word at bank offset 0x04 is the status. It returns the input levels as they were two clock edges before the sampling edge. Writes to it are ignored, and it is the same in every bank.
- R4: The route words sit at bank offsets 0x08, 0x0C, 0x10 and 0x14. The code for input n lives at offset 0x08 + 4*(3 - n/8), bits [4*(n mod 8)+3 : 4*(n mod 8)], so inputs 24 to 31 are in the word at 0x08 and inputs 0 to 7 are in the word at 0x14. Every route word reads back what was written to it.
- R5: Route code 0 disconnects an input. A code c from 1 to 15 drives output line c-1 of that bank and no other line.
- R6: Output k of a bank is the registered OR, over all inputs, of (status bit AND mask bit AND code == k+1). It changes one edge after a register write or a status change, so it changes three edges after an input pin changes. It falls when the inputs that drive it fall.
- R7: Bank b occupies byte addresses 0x20*b to 0x20*b+0x1F and drives irq_out[15*b+14 : 15*b]. Its mask and route codes are separate from those of every other bank.
- R8: Read data is registered and is valid on the cycle after bus_rd. It is 0 on any cycle that follows no read. Offsets 0x18 and 0x1C, and banks that are not present, read 0, and writes to them change nothing.
- R9: Several enabled inputs routed to the same output combine by OR. A cleared mask bit blocks its input no matter what route it has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data follows one cycle later |
| bus_addr | input | 8 | Byte address; bits [7:5] select the bank, bits [4:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | 32 | Level-sensitive interrupt requests, asynchronous to clk |
| irq_out | output | 30 | Level outputs, 15 per bank, two banks |

## Verification
The bench gives every input a distinct route code in each bank and then walks a single active input across all 32 positions. A design that had the route words in ascending order, or that placed fields at the wrong nibble, would light the wrong line or read back a scrambled word. It also sweeps all 16 codes on one input, which exposes an off-by-one between code and line and a code 0 that still drives line 0. It checks the exact edge on which an output follows an input pin or a register write, and that status writes and out-of-range addresses leave the masks and outputs untouched. A design that shared masks between banks would show the other bank's outputs moving.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W        = 32;
  localparam int CODE_W        = 4;
  localparam int FIELDS_PER_WD = DATA_W / CODE_W;
  localparam int BANK_LG       = 5;   // bytes per bank window = 2**BANK_LG
  localparam int WORD_W        = 3;   // word index inside a bank window
  localparam int WORD_MASK     = 0;
  localparam int WORD_STAT     = 1;
  localparam int WORD_ROUTE0   = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_q_n = stage2_q;
endmodule

// File: rtl/irq_lvl_sync.sv
module irq_lvl_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= async_i;
      hold_q <= meta_q;
    end
  end

  assign sync_o = hold_q;
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_route_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int N_OUT = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [WORD_W-1:0]        wr_word,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [N_IN-1:0]          lvl,
  output logic [N_IN-1:0]          mask_o,
  output logic [N_IN*CODE_W-1:0]   route_o,
  output logic [N_OUT-1:0]         irq_o
);
  localparam int ROUTE_WORDS = N_IN / FIELDS_PER_WD;

  logic [N_IN-1:0]        mask_q, mask_d;
  logic [N_IN*CODE_W-1:0] route_q, route_d;
  logic [N_OUT-1:0]       out_q, out_d;

  // Next state of the configuration registers
  always_comb begin
    mask_d  = mask_q;
    route_d = route_q;
    if (wr_word == WORD_W'(WORD_MASK)) begin
      mask_d = wr_data[N_IN-1:0];
    end
    for (int r = 0; r < ROUTE_WORDS; r++) begin
      if (wr_word == WORD_W'(WORD_ROUTE0 + r)) begin
        for (int j = 0; j < FIELDS_PER_WD; j++) begin
          // first route word carries the highest inputs
          route_d[CODE_W*((ROUTE_WORDS-1-r)*FIELDS_PER_WD + j) +: CODE_W] =
            wr_data[CODE_W*j +: CODE_W];
        end
      end
    end
  end

  // Next state of the output lines
  always_comb begin
    out_d = '0;
    for (int k = 0; k < N_OUT; k++) begin
      for (int n = 0; n < N_IN; n++) begin
        if (lvl[n] && mask_q[n] &&
            route_q[CODE_W*n +: CODE_W] == CODE_W'(k + 1)) begin
          out_d[k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      mask_q  <= mask_d;
      route_q <= route_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  assign mask_o  = mask_q;
  assign route_o = route_q;
  assign irq_o   = out_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int N_OUT  = 15,
  parameter int N_BANK = 2,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [N_IN-1:0]         irq_in,
  output logic [N_BANK*N_OUT-1:0] irq_out
);
  localparam int ROUTE_WORDS = N_IN / FIELDS_PER_WD;
  localparam int SEL_W       = ADDR_W - BANK_LG;

  logic                   rst_q_n;
  logic [N_IN-1:0]        lvl_q;
  logic [SEL_W-1:0]       bank_sel;
  logic [WORD_W-1:0]      word_sel;
  logic [N_IN-1:0]        mask_all  [N_BANK];
  logic [N_IN*CODE_W-1:0] route_all [N_BANK];
  logic [N_BANK*N_IN-1:0] mask_flat;
  logic [DATA_W-1:0]      rdata_q, rdata_d;

  assign bank_sel = bus_addr[ADDR_W-1:BANK_LG];
  assign word_sel = bus_addr[BANK_LG-1:2];

  irq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  irq_lvl_sync #(.W(N_IN)) u_sync (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .async_i (irq_in),
    .sync_o  (lvl_q)
  );

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = bus_wr && (bank_sel == SEL_W'(b));

    irq_bank #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_q_n),
      .wr_en   (bank_wr),
      .wr_word (word_sel),
      .wr_data (bus_wdata),
      .lvl     (lvl_q),
      .mask_o  (mask_all[b]),
      .route_o (route_all[b]),
      .irq_o   (irq_out[b*N_OUT +: N_OUT])
    );

    assign mask_flat[b*N_IN +: N_IN] = mask_all[b];
  end

  // Read data selection
  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      for (int b = 0; b < N_BANK; b++) begin
        if (bank_sel == SEL_W'(b)) begin
          if (word_sel == WORD_W'(WORD_MASK)) begin
            rdata_d[N_IN-1:0] = mask_all[b];
          end
          if (word_sel == WORD_W'(WORD_STAT)) begin
            rdata_d[N_IN-1:0] = lvl_q;
          end
          for (int r = 0; r < ROUTE_WORDS; r++) begin
            if (word_sel == WORD_W'(WORD_ROUTE0 + r)) begin
              for (int j = 0; j < FIELDS_PER_WD; j++) begin
                rdata_d[CODE_W*j +: CODE_W] =
                  route_all[b][CODE_W*((ROUTE_WORDS-1-r)*FIELDS_PER_WD + j) +: CODE_W];
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int N_IN   = 32,
  parameter int N_OUT  = 15,
  parameter int N_BANK = 2,
  parameter int ADDR_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic [N_IN-1:0]         lvl_q,
  input logic [N_BANK*N_IN-1:0]  mask_flat,
  input logic [N_BANK*N_OUT-1:0] irq_out
);
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == '0); // R8

  AST_NO_LEVEL_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q == '0 |=> irq_out == '0); // R6

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> mask_flat[N_IN-1:0] == $past(bus_wdata[N_IN-1:0])); // R2

  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(4)) |=> $stable(mask_flat)); // R3

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank_chk
    AST_MASK_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      mask_flat[b*N_IN +: N_IN] == '0 |=> irq_out[b*N_OUT +: N_OUT] == '0); // R9

    AST_SINGLE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(lvl_q) <= 1 |=> $onehot0(irq_out[b*N_OUT +: N_OUT])); // R5
  end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_BANK(N_BANK), .ADDR_W(ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .lvl_q     (lvl_q),
  .mask_flat (mask_flat),
  .irq_out   (irq_out)
);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;
  localparam int NI = 32;
  localparam int NO = 15;
  localparam int NB = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           bus_wr, bus_rd;
  logic [7:0]     bus_addr;
  logic [31:0]    bus_wdata, bus_rdata;
  logic [NI-1:0]  irq_in;
  logic [NB*NO-1:0] irq_out;

  always #2 clk = ~clk;

  irq_route_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mask_m [NB];
  logic [3:0]  route_m [NB][NI];
  logic [31:0] lvl_m;

  function automatic logic [NB*NO-1:0] exp_out();
    logic [NB*NO-1:0] v = '0;
    for (int b = 0; b < NB; b++)
      for (int n = 0; n < NI; n++)
        if (lvl_m[n] && mask_m[b][n] && route_m[b][n] != 4'd0)
          v[b*NO + int'(route_m[b][n]) - 1] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] pack_route(int b, int w);
    logic [31:0] v = '0;
    for (int j = 0; j < 8; j++) v[4*j +: 4] = route_m[b][8*(3-w) + j];
    return v;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic set_lvl(logic [31:0] v);
    @(negedge clk); irq_in = v; lvl_m = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_route(int b, int n, logic [3:0] c);
    route_m[b][n] = c;
    wr(8'(b*32 + 8 + 4*(3 - n/8)), pack_route(b, 3 - n/8));
  endtask

  task automatic set_mask(int b, logic [31:0] m);
    mask_m[b] = m;
    wr(8'(b*32), m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    irq_in = '0; lvl_m = '0;
    for (int b = 0; b < NB; b++) begin
      mask_m[b] = '0;
      for (int n = 0; n < NI; n++) route_m[b][n] = '0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", 64'(irq_out), 64'(0));
    chk("R1 rdata", 64'(bus_rdata), 64'(0));
    for (int b = 0; b < NB; b++) begin
      rd(8'(b*32), d); chk("R1 mask", 64'(d), 64'(0));
      for (int w = 0; w < 4; w++) begin
        rd(8'(b*32 + 8 + 4*w), d); chk("R1 route", 64'(d), 64'(0));
      end
    end

    // R2 mask read/write, R7 banks independent
    set_mask(0, 32'hA5A5_0F0F);
    set_mask(1, 32'h3C3C_F00F);
    rd(8'h00, d); chk("R2 mask bank0", 64'(d), 64'(mask_m[0]));
    rd(8'h20, d); chk("R7 mask bank1", 64'(d), 64'(mask_m[1]));

    // R3 status view and write ignored
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    set_lvl(32'h1234_5678);
    rd(8'h04, d); chk("R3 status", 64'(d), 64'(32'h1234_5678));
    rd(8'h24, d); chk("R3 status bank1", 64'(d), 64'(32'h1234_5678));
    rd(8'h00, d); chk("R3 status write ignored", 64'(d), 64'(mask_m[0]));
    chk("R3 outputs unaffected", 64'(irq_out), 64'(exp_out()));

    // R4 route layout
    for (int b = 0; b < NB; b++) begin
      for (int n = 0; n < NI; n++) route_m[b][n] = 4'((n*5 + b*7 + 1) % 16);
      for (int w = 0; w < 4; w++) wr(8'(b*32 + 8 + 4*w), pack_route(b, w));
    end
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < 4; w++) begin
        rd(8'(b*32 + 8 + 4*w), d); chk("R4 route readback", 64'(d), 64'(pack_route(b, w)));
      end
    // R4 single field placement: input 30 lives in word 0x08 bits 27:24
    set_route(0, 30, 4'hB);
    rd(8'h08, d); chk("R4 input30 field", 64'(d[27:24]), 64'(4'hB));

    // R5 walk a single input over all positions
    set_mask(0, 32'hFFFF_FFFF);
    set_mask(1, 32'hFFFF_FFFF);
    for (int n = 0; n < NI; n++) begin
      set_lvl(32'h1 << n);
      chk("R5 walk", 64'(irq_out), 64'(exp_out()));
    end

    // R5 every code on input 9 of bank 1
    set_lvl(32'h1 << 9);
    for (int c = 0; c < 16; c++) begin
      set_route(1, 9, 4'(c));
      repeat (2) @(negedge clk);
      chk("R5 code sweep", 64'(irq_out), 64'(exp_out()));
    end

    // R9 OR combining and masking
    set_route(0, 3, 4'd4); set_route(0, 17, 4'd4); set_route(0, 28, 4'd4);
    set_lvl(32'h1002_0008);
    chk("R9 shared line", 64'(irq_out[3]), 64'(1));
    chk("R9 OR pattern", 64'(irq_out), 64'(exp_out()));
    set_lvl(32'hFFFF_FFFF);
    chk("R9 all on", 64'(irq_out), 64'(exp_out()));
    set_mask(0, 32'h0F0F_0F0F);
    repeat (2) @(negedge clk);
    chk("R9 partial mask", 64'(irq_out), 64'(exp_out()));
    set_mask(0, 32'h0);
    repeat (2) @(negedge clk);
    chk("R9 mask zero bank0", 64'(irq_out[NO-1:0]), 64'(0));
    chk("R7 bank1 unaffected", 64'(irq_out), 64'(exp_out()));

    // R6 timing from input pin
    set_mask(0, 32'hFFFF_FFFF);
    set_lvl(32'h0);
    chk("R6 fall", 64'(irq_out), 64'(0));
    @(negedge clk); irq_in = 32'h0000_0100; lvl_m = 32'h0000_0100;
    @(negedge clk); @(negedge clk);
    chk("R6 not yet after two edges", 64'(irq_out), 64'(0));
    @(negedge clk);
    chk("R6 third edge", 64'(irq_out), 64'(exp_out()));
    // R6 timing from register write
    @(negedge clk); bus_wr = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h0;
    @(negedge clk); bus_wr = 1'b0;
    chk("R6 old value after write edge", 64'(irq_out[NO-1:0]), 64'(exp_out() & {NB*NO{1'b1}}) & 64'h7FFF);
    mask_m[0] = 32'h0;
    @(negedge clk);
    chk("R6 one edge after write", 64'(irq_out), 64'(exp_out()));

    // R8 unmapped offsets and banks
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h18, d); chk("R8 offset 0x18", 64'(d), 64'(0));
    rd(8'h1C, d); chk("R8 offset 0x1C", 64'(d), 64'(0));
    rd(8'h60, d); chk("R8 absent bank", 64'(d), 64'(0));
    rd(8'h00, d); chk("R8 mask untouched", 64'(d), 64'(mask_m[0]));
    rd(8'h20, d); chk("R8 bank1 mask untouched", 64'(d), 64'(mask_m[1]));
    for (int w = 0; w < 4; w++) begin
      rd(8'(8 + 4*w), d); chk("R8 routes untouched", 64'(d), 64'(pack_route(0, w)));
    end
    @(negedge clk);
    chk("R8 idle rdata", 64'(bus_rdata), 64'(0));
    chk("R8 outputs untouched", 64'(irq_out), 64'(exp_out()));

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule